// File: doc/BRIEF.md
# Floating-Point Context Status Tracker

This block holds the machine status register bits that describe the state of the floating-point context, and a second copy of the same register that belongs to a virtualized guest. The context state is a 2-bit field with four values: off, initial, clean and dirty. A summary bit in the most significant position reports that at least one context field in the register is dirty. Software can replace either register with a full-width write. The execution units send a one-cycle pulse each time an instruction changes floating-point state. The block then promotes an initial or clean field to dirty, sets the summary bit, and applies the same promotion to the guest copy while virtualization is active.

Bits outside the context field and the summary bit are stored and returned unchanged. The block also drives a registered permission flag that downstream issue logic uses to decide whether floating-point instructions may run. A one-cycle mark pulse is driven for each register whenever an automatic promotion actually writes it. A mirror elsewhere can use this pulse to skip redundant write-backs.

Top module: `fp_ctx_tracker`

## Requirements
- R1: With reset active at a rising clock edge, both status registers become all zeros, and the permission flag and both mark pulses become 0.
- R2: The context field occupies bits [14:13] of each register and is encoded as 0 off, 1 initial, 2 clean, 3 dirty. `fp_allowed` is 1 exactly when the host field is nonzero and, while `virt_on` is 1, the guest field is also nonzero. It is registered and reflects the register contents after the same clock edge.
- R3: A modify pulse while the host field is 1 or 2 changes the field to 3 and sets bit 63. `host_marked` is 1 in the cycle after that edge and 0 again after the next edge if no further promotion occurs.
- R4: A modify pulse while a field is already 3 writes nothing: that register keeps its value and its mark pulse stays 0.
- R5: While the host field is 0, a modify pulse is ignored for both registers, with no mark pulse.
- R6: While `virt_on` is 1, a modify pulse with host field nonzero also promotes a guest field of 1 or 2 to 3, sets guest bit 63 and pulses `guest_marked`. While `virt_on` is 0, the guest register is untouched.
- R7: A software write stores every bit of the write data except bit 63. Bit 63 becomes 1 exactly when at least one of bits [14:13], [10:9] or [16:15] of the data equals 3.
- R8: When a software write and a modify pulse reach the same register in one cycle, the written value is stored and that register's mark pulse stays 0.
- R9: A promotion changes only the context field and bit 63; all other bits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Software write strobe for the host status register |
| host_wr_data | input | 64 | Host write data |
| guest_wr_en | input | 1 | Software write strobe for the guest status copy |
| guest_wr_data | input | 64 | Guest write data |
| virt_on | input | 1 | Virtualized guest context active |
| fp_mod | input | 1 | One-cycle pulse: floating-point state was modified |
| host_status | output | 64 | Host status register contents |
| guest_status | output | 64 | Guest status register contents |
| fp_allowed | output | 1 | Floating-point instructions permitted |
| host_marked | output | 1 | Host register was written by a promotion |
| guest_marked | output | 1 | Guest register was written by a promotion |

## Verification
The bench sends modify pulses while the field is already dirty. A design that rewrites the register anyway would produce a spurious mark pulse. It sends pulses with the host field off, where a design that forgets the gate would make the context dirty even though floating-point instructions are forbidden. It sends pulses with virtualization toggled and with the guest field in each state, which catches a guest copy that is promoted while virtualization is inactive or left stale while it is active. Same-cycle collisions of a write and a pulse, and writes that set or clear the summary bit through other dirty fields, expose a wrong priority and a summary bit taken from the data instead of recomputed.

// File: rtl/fsdt_pkg.sv
package fsdt_pkg;

  typedef enum logic [1:0] {
    FS_OFF   = 2'd0,
    FS_INIT  = 2'd1,
    FS_CLEAN = 2'd2,
    FS_DIRTY = 2'd3
  } ctx_state_e;

  localparam int NUM_CTX = 2;
  localparam int CTX_HOST  = 0;
  localparam int CTX_GUEST = 1;

  function automatic logic any_dirty(input logic [1:0] a,
                                     input logic [1:0] b,
                                     input logic [1:0] c);
    return (a == FS_DIRTY) || (b == FS_DIRTY) || (c == FS_DIRTY);
  endfunction

  function automatic logic can_promote(input logic [1:0] fs);
    return (fs == FS_INIT) || (fs == FS_CLEAN);
  endfunction

endpackage

// File: rtl/fsdt_ctx_reg.sv
module fsdt_ctx_reg
  import fsdt_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int FS_LSB = 13,
  parameter int VS_LSB = 9,
  parameter int XS_LSB = 15
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_data,
  input  logic            mark_req,
  output logic [XLEN-1:0] stat_o,
  output logic [1:0]      fs_next_o,
  output logic            marked_o
);

  localparam int SD_BIT = XLEN - 1;
  localparam logic [XLEN-1:0] KEEP_MASK =
    ~(({{(XLEN-2){1'b0}}, 2'b11} << FS_LSB) | ({{(XLEN-1){1'b0}}, 1'b1} << SD_BIT));

  logic [XLEN-1:0] stat_q, stat_d;
  logic            mark_q, mark_d;
  logic [1:0]      fs_cur;

  assign fs_cur = stat_q[FS_LSB +: 2];

  always_comb begin
    stat_d = stat_q;
    mark_d = 1'b0;
    if (wr_en) begin
      stat_d         = wr_data;
      stat_d[SD_BIT] = any_dirty(wr_data[FS_LSB +: 2], wr_data[VS_LSB +: 2],
                                 wr_data[XS_LSB +: 2]);
    end else if (mark_req && can_promote(fs_cur)) begin
      stat_d[FS_LSB +: 2] = FS_DIRTY;
      stat_d[SD_BIT]      = 1'b1;
      mark_d              = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mark_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
      mark_q <= mark_d;
    end
  end

  assign stat_o    = stat_q;
  assign fs_next_o = stat_d[FS_LSB +: 2];
  assign marked_o  = mark_q;

  // R3: a mark pulse always accompanies a dirty field and a set summary bit
  a_r3_mark_sets_dirty: assert property (@(posedge clk) disable iff (rst)
    mark_q |-> (stat_q[FS_LSB +: 2] == FS_DIRTY) && stat_q[SD_BIT]);

  // R4: an already dirty field is not rewritten
  a_r4_dirty_no_write: assert property (@(posedge clk) disable iff (rst)
    (mark_req && !wr_en && fs_cur == FS_DIRTY) |=> ($stable(stat_q) && !mark_q));

  // R7: the summary bit follows the dirty fields held in the register
  a_r7_summary_consistent: assert property (@(posedge clk) disable iff (rst)
    stat_q[SD_BIT] == any_dirty(stat_q[FS_LSB +: 2], stat_q[VS_LSB +: 2],
                                stat_q[XS_LSB +: 2]));

  // R8: a software write suppresses the mark pulse
  a_r8_write_wins: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !mark_q);

  // R9: without a write, bits outside the field and summary bit hold
  a_r9_other_bits_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ((stat_q & KEEP_MASK) == ($past(stat_q) & KEEP_MASK)));

endmodule

// File: rtl/fsdt_gate.sv
module fsdt_gate
  import fsdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       virt_on,
  input  logic [1:0] host_fs_next,
  input  logic [1:0] guest_fs_next,
  output logic       allowed_o
);

  logic allowed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      allowed_q <= 1'b0;
    end else begin
      allowed_q <= (host_fs_next != FS_OFF) &&
                   (!virt_on || (guest_fs_next != FS_OFF));
    end
  end

  assign allowed_o = allowed_q;

  // R2: an off host field forbids floating-point instructions
  a_r2_off_blocks: assert property (@(posedge clk) disable iff (rst)
    (host_fs_next == FS_OFF) |=> !allowed_q);

endmodule

// File: rtl/fp_ctx_tracker.sv
module fp_ctx_tracker
  import fsdt_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int FS_LSB = 13,
  parameter int VS_LSB = 9,
  parameter int XS_LSB = 15
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_wr_en,
  input  logic [XLEN-1:0] host_wr_data,
  input  logic            guest_wr_en,
  input  logic [XLEN-1:0] guest_wr_data,
  input  logic            virt_on,
  input  logic            fp_mod,
  output logic [XLEN-1:0] host_status,
  output logic [XLEN-1:0] guest_status,
  output logic            fp_allowed,
  output logic            host_marked,
  output logic            guest_marked
);

  logic [NUM_CTX-1:0]           wr_en_v;
  logic [NUM_CTX-1:0][XLEN-1:0] wr_data_v;
  logic [NUM_CTX-1:0]           mark_req_v;
  logic [NUM_CTX-1:0][XLEN-1:0] stat_v;
  logic [NUM_CTX-1:0][1:0]      fs_next_v;
  logic [NUM_CTX-1:0]           marked_v;
  logic                         host_live;

  assign host_live = stat_v[CTX_HOST][FS_LSB +: 2] != FS_OFF;

  assign wr_en_v[CTX_HOST]     = host_wr_en;
  assign wr_en_v[CTX_GUEST]    = guest_wr_en;
  assign wr_data_v[CTX_HOST]   = host_wr_data;
  assign wr_data_v[CTX_GUEST]  = guest_wr_data;
  assign mark_req_v[CTX_HOST]  = fp_mod && host_live;
  assign mark_req_v[CTX_GUEST] = fp_mod && host_live && virt_on;

  for (genvar gi = 0; gi < NUM_CTX; gi++) begin : g_ctx
    fsdt_ctx_reg #(
      .XLEN  (XLEN),
      .FS_LSB(FS_LSB),
      .VS_LSB(VS_LSB),
      .XS_LSB(XS_LSB)
    ) ctx_i (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en_v[gi]),
      .wr_data  (wr_data_v[gi]),
      .mark_req (mark_req_v[gi]),
      .stat_o   (stat_v[gi]),
      .fs_next_o(fs_next_v[gi]),
      .marked_o (marked_v[gi])
    );
  end

  fsdt_gate gate_i (
    .clk          (clk),
    .rst          (rst),
    .virt_on      (virt_on),
    .host_fs_next (fs_next_v[CTX_HOST]),
    .guest_fs_next(fs_next_v[CTX_GUEST]),
    .allowed_o    (fp_allowed)
  );

  assign host_status  = stat_v[CTX_HOST];
  assign guest_status = stat_v[CTX_GUEST];
  assign host_marked  = marked_v[CTX_HOST];
  assign guest_marked = marked_v[CTX_GUEST];

  // R5: with the host field off, a modify pulse marks nothing
  a_r5_off_no_mark: assert property (@(posedge clk) disable iff (rst)
    (fp_mod && !host_live) |=> (!host_marked && !guest_marked));

  // R6: guest copy untouched while virtualization is inactive
  a_r6_guest_idle: assert property (@(posedge clk) disable iff (rst)
    (!virt_on && !guest_wr_en) |=> $stable(guest_status));

endmodule

// File: tb/fp_ctx_tracker_tb_top.sv
`timescale 1ns/1ps
module fp_ctx_tracker_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr_en = 1'b0, guest_wr_en = 1'b0;
  logic [63:0] host_wr_data = '0, guest_wr_data = '0;
  logic        virt_on = 1'b0, fp_mod = 1'b0;
  logic [63:0] host_status, guest_status;
  logic        fp_allowed, host_marked, guest_marked;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fp_ctx_tracker dut_i (
    .clk(clk), .rst(rst),
    .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .guest_wr_en(guest_wr_en), .guest_wr_data(guest_wr_data),
    .virt_on(virt_on), .fp_mod(fp_mod),
    .host_status(host_status), .guest_status(guest_status),
    .fp_allowed(fp_allowed), .host_marked(host_marked),
    .guest_marked(guest_marked)
  );

  // Build a register image: base bits, then fields at [14:13], [10:9], [16:15]
  function automatic logic [63:0] img(logic [63:0] base, logic [1:0] fs,
                                      logic [1:0] vs, logic [1:0] xs);
    logic [63:0] r = base;
    r[14:13] = fs; r[10:9] = vs; r[16:15] = xs;
    return r;
  endfunction

  // Expected stored value after a software write (R7)
  function automatic logic [63:0] stored(logic [63:0] d);
    logic [63:0] r = d;
    r[63] = (d[14:13] == 2'd3) || (d[10:9] == 2'd3) || (d[16:15] == 2'd3);
    return r;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs at the falling edge, sample after the rising edge
  task automatic cyc(logic hwe, logic [63:0] hd, logic gwe, logic [63:0] gd,
                     logic v, logic m);
    @(negedge clk);
    host_wr_en = hwe; host_wr_data = hd;
    guest_wr_en = gwe; guest_wr_data = gd;
    virt_on = v; fp_mod = m;
    @(posedge clk); #1;
    host_wr_en = 0; guest_wr_en = 0; fp_mod = 0;
  endtask

  task automatic t_reset();
    chk("R1 host", host_status, 64'd0);
    chk("R1 guest", guest_status, 64'd0);
    chk("R1 allowed", {63'd0, fp_allowed}, 64'd0);
    chk("R1 marks", {62'd0, host_marked, guest_marked}, 64'd0);
  endtask

  task automatic t_write_summary();
    logic [63:0] d;
    d = img(64'h0123_4567_0000_0000, 2'd1, 2'd3, 2'd0);
    cyc(1, d, 0, '0, 0, 0);
    chk("R7 vs dirty sets summary", host_status, stored(d));
    chk("R2 allowed initial", {63'd0, fp_allowed}, 64'd1);
    d = img(64'h8000_0000_0000_0A5A, 2'd2, 2'd0, 2'd1);
    cyc(1, d, 0, '0, 0, 0);
    chk("R7 summary cleared", host_status, stored(d));
    d = img(64'h0, 2'd0, 2'd0, 2'd3);
    cyc(1, d, 0, '0, 0, 0);
    chk("R7 xs dirty", host_status, stored(d));
    chk("R2 off blocks", {63'd0, fp_allowed}, 64'd0);
  endtask

  task automatic t_promote();
    logic [63:0] d;
    for (int s = 1; s <= 2; s++) begin
      d = img(64'h0000_0F00_F000_0001, 2'(s), 2'd0, 2'd0);
      cyc(1, d, 0, '0, 0, 0);
      cyc(0, '0, 0, '0, 0, 1);
      chk("R3 promote", host_status, img(stored(d), 2'd3, 2'd0, 2'd0) | 64'h8000_0000_0000_0000);
      chk("R9 other bits kept", host_status & ~64'h8000_0000_0000_6000,
          d & ~64'h8000_0000_0000_6000);
      chk("R3 mark pulse", {63'd0, host_marked}, 64'd1);
      cyc(0, '0, 0, '0, 0, 0);
      chk("R3 pulse ends", {63'd0, host_marked}, 64'd0);
    end
  endtask

  task automatic t_dirty_noop();
    logic [63:0] d;
    d = img(64'h0000_0000_00F0_0000, 2'd3, 2'd0, 2'd0);
    cyc(1, d, 0, '0, 0, 0);
    cyc(0, '0, 0, '0, 0, 1);
    chk("R4 dirty unchanged", host_status, stored(d));
    chk("R4 no pulse", {63'd0, host_marked}, 64'd0);
  endtask

  task automatic t_off();
    logic [63:0] g;
    g = img(64'h0, 2'd1, 2'd0, 2'd0);
    cyc(1, img(64'h0, 2'd0, 2'd0, 2'd0), 1, g, 1, 0);
    chk("R2 host off", {63'd0, fp_allowed}, 64'd0);
    cyc(0, '0, 0, '0, 1, 1);
    chk("R5 host ignored", host_status, 64'd0);
    chk("R5 guest ignored", guest_status, stored(g));
    chk("R5 no pulses", {62'd0, host_marked, guest_marked}, 64'd0);
  endtask

  task automatic t_virt();
    logic [63:0] h, g;
    h = img(64'h0, 2'd1, 2'd0, 2'd0);
    g = img(64'h0000_0000_0000_0003, 2'd2, 2'd0, 2'd0);
    cyc(1, h, 1, g, 1, 0);
    chk("R2 both live", {63'd0, fp_allowed}, 64'd1);
    cyc(0, '0, 0, '0, 1, 1);
    chk("R6 guest promoted", guest_status, stored(img(g, 2'd3, 2'd0, 2'd0)));
    chk("R6 host promoted", host_status, stored(img(h, 2'd3, 2'd0, 2'd0)));
    chk("R6 both pulses", {62'd0, host_marked, guest_marked}, 64'd3);
    h = img(64'h0, 2'd1, 2'd0, 2'd0);
    g = img(64'h0, 2'd1, 2'd0, 2'd0);
    cyc(1, h, 1, g, 0, 0);
    cyc(0, '0, 0, '0, 0, 1);
    chk("R6 guest untouched", guest_status, stored(g));
    chk("R6 no guest pulse", {63'd0, guest_marked}, 64'd0);
    cyc(1, h, 1, img(64'h0, 2'd0, 2'd0, 2'd0), 1, 0);
    chk("R2 guest off blocks", {63'd0, fp_allowed}, 64'd0);
    cyc(0, '0, 0, '0, 0, 0);
    chk("R2 virt off allows", {63'd0, fp_allowed}, 64'd1);
  endtask

  task automatic t_collide();
    logic [63:0] d;
    cyc(1, img(64'h0, 2'd1, 2'd0, 2'd0), 0, '0, 0, 0);
    d = img(64'h0000_0000_0000_00C0, 2'd2, 2'd0, 2'd0);
    cyc(1, d, 0, '0, 0, 1);
    chk("R8 write wins", host_status, stored(d));
    chk("R8 no pulse", {63'd0, host_marked}, 64'd0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst = 0;
    t_write_summary();
    t_promote();
    t_dirty_noop();
    t_off();
    t_virt();
    t_collide();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule